// File: doc/BRIEF.md
# Colour Subcarrier and Burst Generator

This block is the timing heart of a digital composite/S-video encoder. A phase accumulator running on the 27 MHz sample clock produces the colour subcarrier for NTSC, PAL or PAL-M as signed sine and cosine samples, ready for a quadrature chroma modulator downstream. A third output carries the V-axis carrier, whose sign follows the PAL line switch. A PAL line switch of 1 both inverts V and moves the burst from 135 to 225 degrees relative to U.

The oscillator is not free-running. It is pulled to zero phase on the first line of the first field of every colour frame: every four fields in NTSC and every eight in the PAL variants. This keeps the subcarrier-to-sync relation repeatable.

After each line start, a burst-gate window opens at a fixed offset. It stays open for a number of whole subcarrier cycles that depends on the standard, counted as accumulator overflows. Mode 11 puts the encoder to sleep.

Top module: `chroma_subcarrier_gen`

## Requirements
- R1: While reset is asserted, sin_o, cos_o, v_o, burst_gate and pal_sw are all zero.
- R2: Each clock, the 32-bit accumulator advances by round(f × 2^32 / 27 000 000). The mode code selects f: 00 gives 3 579 545 Hz (NTSC), 01 gives 4 433 619 Hz (PAL), and 10 gives 3 575 611 Hz (PAL-M).
- R3: One clock after the accumulator holds phase p (its top 8 bits), sin_o equals round(255·sin(2π(p+0.5)/256)), with halves rounded away from zero. cos_o is the same function of (p+64) mod 256. Both outputs are 9-bit two's complement.
- R4: A line_start with line_num equal to 1 is a frame reference and clears the accumulator to zero at that edge, provided field_idx matches. In NTSC, field_idx[1:0] must be 00. In PAL and PAL-M, all three bits of field_idx must be 000. A line_start on any other line or field leaves the phase running.
- R5: burst_gate rises on the 76th clock edge after the edge that captures line_start. This is 38 pixel periods of two clocks each.
- R6: burst_gate falls on the edge where the accumulator completes its 9th overflow (NTSC, PAL-M) or 10th overflow (PAL) since the gate rose.
- R7: A line_start while the gate is waiting or open restarts the delay, and the gate is low on the next cycle.
- R8: In PAL, pal_sw toggles at every line_start. In every other mode it is 0 from the next clock.
- R9: v_o equals cos_o when pal_sw was 0 in the preceding cycle, and equals −cos_o when it was 1.
- R10: In mode 11 (sleep), the accumulator is held at zero, sin_o, cos_o and v_o are zero, the gate is closed and pal_sw is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Standard select: 00 NTSC, 01 PAL, 10 PAL-M, 11 sleep |
| line_start | input | 1 | One-clock pulse at the horizontal sync falling edge |
| line_num | input | 10 | Line number of the line now starting |
| field_idx | input | 3 | Field position inside the colour frame sequence |
| sin_o | output | 9 | Signed subcarrier sine sample |
| cos_o | output | 9 | Signed subcarrier cosine sample |
| v_o | output | 9 | Signed V-axis carrier, sign set by the PAL switch |
| burst_gate | output | 1 | High while the colour burst is to be inserted |
| pal_sw | output | 1 | PAL line alternation switch |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, an 8-bit table index, 9-bit samples and a 38-pixel burst offset. With these values the real frequency words of all three standards are exercised, and a few thousand clocks sweep every table entry and both signs. Lines of 200 clocks keep each full burst window inside one line. Shortened lines force the restart path. Field indices 4 and 1 separate the NTSC and PAL frame-reference masks.

// File: rtl/scg_pkg.sv
package scg_pkg;

  typedef enum logic [1:0] {
    STD_NTSC  = 2'b00,
    STD_PAL   = 2'b01,
    STD_PALM  = 2'b10,
    STD_SLEEP = 2'b11
  } std_e;

  typedef enum logic [1:0] {
    BG_IDLE = 2'b00,
    BG_WAIT = 2'b01,
    BG_OPEN = 2'b10
  } bg_state_e;

  localparam longint unsigned SAMPLE_HZ = 64'd27000000;
  localparam real SCG_PI = 3.141592653589793;

  // rounded frequency word: f * 2^acc_w / fs
  function automatic longint unsigned phase_step(input longint unsigned f_hz, input int acc_w);
    longint unsigned num;
    num = (f_hz << acc_w) + SAMPLE_HZ / 2;
    return num / SAMPLE_HZ;
  endfunction

endpackage

// File: rtl/scg_phase_acc.sv
module scg_phase_acc
  import scg_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 8,
  parameter longint unsigned NTSC_HZ = 64'd3579545,
  parameter longint unsigned PAL_HZ  = 64'd4433619,
  parameter longint unsigned PALM_HZ = 64'd3575611
) (
  input  logic             clk,
  input  logic             rst_n,
  input  std_e             std,
  input  logic             clear,
  output logic [PH_W-1:0]  phase_top,
  output logic             wrap
);

  localparam logic [ACC_W-1:0] STEP_NTSC = ACC_W'(phase_step(NTSC_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_PAL  = ACC_W'(phase_step(PAL_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_PALM = ACC_W'(phase_step(PALM_HZ, ACC_W));

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_nx;
  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   sum;
  logic             acc_en;

  always_comb begin
    case (std)
      STD_PAL:  step = STEP_PAL;
      STD_PALM: step = STEP_PALM;
      default:  step = STEP_NTSC;
    endcase
  end

  assign sum    = {1'b0, phase_q} + {1'b0, step};
  assign acc_en = 1'b1;

  always_comb begin
    if (std == STD_SLEEP || clear) begin
      phase_nx = '0;
      wrap     = 1'b0;
    end else begin
      phase_nx = sum[ACC_W-1:0];
      wrap     = sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (acc_en) begin
      phase_q <= phase_nx;
    end
  end

  assign phase_top = phase_q[ACC_W-1 -: PH_W];

endmodule

// File: rtl/scg_quarter_sine.sv
module scg_quarter_sine
  import scg_pkg::*;
#(
  parameter int PH_W  = 8,
  parameter int SIN_W = 9
) (
  input  logic [PH_W-1:0]         ph,
  output logic signed [SIN_W-1:0] val
);

  localparam int  QW  = PH_W - 2;
  localparam int  QN  = 2 ** QW;
  localparam real AMP = real'(2 ** (SIN_W - 1) - 1);

  logic [SIN_W-1:0] qtab [QN];

  // first quadrant, sampled at half-step offsets so the mirror needs no special case
  for (genvar j = 0; j < QN; j++) begin : g_qtab
    localparam real TH = 2.0 * SCG_PI * (real'(j) + 0.5) / real'(4 * QN);
    localparam int  QV = $rtoi(AMP * $sin(TH) + 0.5);
    assign qtab[j] = SIN_W'(QV);
  end

  logic [1:0]              quad;
  logic [QW-1:0]           off;
  logic [QW-1:0]           idx;
  logic signed [SIN_W-1:0] mag;

  always_comb begin
    quad = ph[PH_W-1 -: 2];
    off  = ph[QW-1:0];
    idx  = quad[0] ? ~off : off;
    mag  = $signed(qtab[idx]);
    val  = quad[1] ? -mag : mag;
  end

endmodule

// File: rtl/scg_burst_gate.sv
module scg_burst_gate
  import scg_pkg::*;
#(
  parameter int DLY_CLKS = 76,
  parameter int NTSC_CYC = 9,
  parameter int PAL_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  std_e std,
  input  logic line_start,
  input  logic wrap,
  output logic gate
);

  localparam int DLY_W   = $clog2(DLY_CLKS + 1);
  localparam int CYC_MAX = (PAL_CYC > NTSC_CYC) ? PAL_CYC : NTSC_CYC;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  bg_state_e        state_q, state_nx;
  logic [DLY_W-1:0] dly_q, dly_nx;
  logic [CNT_W-1:0] wcnt_q, wcnt_nx;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = (std == STD_PAL) ? CNT_W'(PAL_CYC - 1) : CNT_W'(NTSC_CYC - 1);

  always_comb begin
    state_nx = state_q;
    dly_nx   = dly_q;
    wcnt_nx  = wcnt_q;
    if (std == STD_SLEEP) begin
      state_nx = BG_IDLE;
    end else if (line_start) begin
      state_nx = BG_WAIT;
      dly_nx   = DLY_W'(DLY_CLKS - 1);
      wcnt_nx  = '0;
    end else begin
      case (state_q)
        BG_WAIT: begin
          if (dly_q == '0) begin
            state_nx = BG_OPEN;
            wcnt_nx  = '0;
          end else begin
            dly_nx = dly_q - 1'b1;
          end
        end
        BG_OPEN: begin
          if (wrap) begin
            if (wcnt_q == last_cnt) state_nx = BG_IDLE;
            else                    wcnt_nx  = wcnt_q + 1'b1;
          end
        end
        default: state_nx = BG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BG_IDLE;
      dly_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_nx;
      dly_q   <= dly_nx;
      wcnt_q  <= wcnt_nx;
    end
  end

  assign gate = (state_q == BG_OPEN);

endmodule

// File: rtl/chroma_subcarrier_gen.sv
module chroma_subcarrier_gen
  import scg_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int PH_W        = 8,
  parameter int SIN_W       = 9,
  parameter int LINE_W      = 10,
  parameter int REF_LINE    = 1,
  parameter int PIX_DELAY   = 38,
  parameter int CLK_PER_PIX = 2,
  parameter int NTSC_CYC    = 9,
  parameter int PAL_CYC     = 10,
  parameter longint unsigned NTSC_HZ = 64'd3579545,
  parameter longint unsigned PAL_HZ  = 64'd4433619,
  parameter longint unsigned PALM_HZ = 64'd3575611
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    line_start,
  input  logic [LINE_W-1:0]       line_num,
  input  logic [2:0]              field_idx,
  output logic signed [SIN_W-1:0] sin_o,
  output logic signed [SIN_W-1:0] cos_o,
  output logic signed [SIN_W-1:0] v_o,
  output logic                    burst_gate,
  output logic                    pal_sw
);

  localparam int DLY_CLKS = PIX_DELAY * CLK_PER_PIX;
  localparam int QN       = 2 ** (PH_W - 2);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  std_e std;
  assign std = std_e'(mode);

  logic field_first;
  logic frame_ref;

  always_comb begin
    if (std == STD_NTSC) field_first = (field_idx[1:0] == 2'b00);
    else                 field_first = (field_idx == 3'b000);
    frame_ref = line_start && (line_num == LINE_W'(REF_LINE)) && field_first;
  end

  logic [PH_W-1:0]         phase_top;
  logic                    wrap;
  logic signed [SIN_W-1:0] lut_sin, lut_cos;

  scg_phase_acc #(
    .ACC_W(ACC_W), .PH_W(PH_W),
    .NTSC_HZ(NTSC_HZ), .PAL_HZ(PAL_HZ), .PALM_HZ(PALM_HZ)
  ) u_acc (
    .clk(clk), .rst_n(rst_n_int), .std(std), .clear(frame_ref),
    .phase_top(phase_top), .wrap(wrap)
  );

  scg_quarter_sine #(.PH_W(PH_W), .SIN_W(SIN_W)) u_sin (
    .ph(phase_top), .val(lut_sin)
  );

  scg_quarter_sine #(.PH_W(PH_W), .SIN_W(SIN_W)) u_cos (
    .ph(phase_top + PH_W'(QN)), .val(lut_cos)
  );

  scg_burst_gate #(
    .DLY_CLKS(DLY_CLKS), .NTSC_CYC(NTSC_CYC), .PAL_CYC(PAL_CYC)
  ) u_gate (
    .clk(clk), .rst_n(rst_n_int), .std(std), .line_start(line_start),
    .wrap(wrap), .gate(burst_gate)
  );

  // PAL line switch
  logic sw_q, sw_nx;

  always_comb begin
    sw_nx = sw_q;
    if (std != STD_PAL)  sw_nx = 1'b0;
    else if (line_start) sw_nx = ~sw_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sw_q <= 1'b0;
    else            sw_q <= sw_nx;
  end
  assign pal_sw = sw_q;

  // output sample registers
  logic signed [SIN_W-1:0] sin_nx, cos_nx, v_nx;

  always_comb begin
    if (std == STD_SLEEP) begin
      sin_nx = '0;
      cos_nx = '0;
      v_nx   = '0;
    end else begin
      sin_nx = lut_sin;
      cos_nx = lut_cos;
      v_nx   = sw_q ? -lut_cos : lut_cos;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sin_o <= '0;
      cos_o <= '0;
      v_o   <= '0;
    end else begin
      sin_o <= sin_nx;
      cos_o <= cos_nx;
      v_o   <= v_nx;
    end
  end

endmodule

// File: rtl/chroma_subcarrier_gen_chk.sv
module chroma_subcarrier_gen_chk
  import scg_pkg::*;
#(
  parameter int PH_W   = 8,
  parameter int SIN_W  = 9,
  parameter int LINE_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode,
  input logic                    line_start,
  input logic [LINE_W-1:0]       line_num,
  input logic [2:0]              field_idx,
  input logic signed [SIN_W-1:0] sin_o,
  input logic signed [SIN_W-1:0] cos_o,
  input logic signed [SIN_W-1:0] v_o,
  input logic                    burst_gate,
  input logic                    pal_sw
);

  localparam int  QN      = 2 ** (PH_W - 2);
  localparam real AMP     = real'(2 ** (SIN_W - 1) - 1);
  localparam int  FIRST_S = $rtoi(AMP * $sin(SCG_PI / real'(4 * QN)) + 0.5);
  localparam int  FIRST_C = $rtoi(AMP * $sin(2.0 * SCG_PI * (real'(QN) + 0.5) / real'(4 * QN)) + 0.5);

  logic ref_seen;
  assign ref_seen = line_start && (line_num == LINE_W'(1)) &&
                    ((mode == 2'b00) ? (field_idx[1:0] == 2'b00) : (field_idx == 3'b000));

  AST_GENLOCK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_seen && mode != 2'b11) ##1 (mode != 2'b11) |=> (int'(sin_o) == FIRST_S && int'(cos_o) == FIRST_C)); // R4

  AST_GATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !burst_gate); // R7

  AST_SW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && line_start) |=> (pal_sw != $past(pal_sw))); // R8

  AST_SW_NONPAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |=> !pal_sw); // R8

  AST_V_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pal_sw) |-> (v_o == cos_o)); // R9

  AST_V_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pal_sw) |-> (v_o == -cos_o)); // R9

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (sin_o == '0 && cos_o == '0 && v_o == '0 && !burst_gate && !pal_sw)); // R10

endmodule

bind chroma_subcarrier_gen chroma_subcarrier_gen_chk #(
  .PH_W(PH_W), .SIN_W(SIN_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .mode(mode), .line_start(line_start),
  .line_num(line_num), .field_idx(field_idx), .sin_o(sin_o), .cos_o(cos_o),
  .v_o(v_o), .burst_gate(burst_gate), .pal_sw(pal_sw)
);

// File: tb/chroma_subcarrier_gen_test.sv
module chroma_subcarrier_gen_test;

  logic              clk;
  logic              rst_n;
  logic [1:0]        mode;
  logic              line_start;
  logic [9:0]        line_num;
  logic [2:0]        field_idx;
  logic signed [8:0] sin_o, cos_o, v_o;
  logic              burst_gate, pal_sw;

  chroma_subcarrier_gen uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_start(line_start),
    .line_num(line_num), .field_idx(field_idx), .sin_o(sin_o), .cos_o(cos_o),
    .v_o(v_o), .burst_gate(burst_gate), .pal_sw(pal_sw)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit ok;
    bit slp;
    int s, c, v, g, sw;
  } exp_t;

  exp_t q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tab(input int p);
    real x;
    x = 255.0 * $sin(2.0 * 3.141592653589793 * (real'(p % 256) + 0.5) / 256.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  // R2 frequency words from the stated formula
  function automatic longint unsigned step_of(input logic [1:0] m);
    longint unsigned f;
    case (m)
      2'b01:   f = 64'd4433619;
      2'b10:   f = 64'd3575611;
      default: f = 64'd3579545;
    endcase
    return ((f << 32) + 64'd13500000) / 64'd27000000;
  endfunction

  function automatic bit is_ref();
    bit fm;
    fm = (mode == 2'b00) ? (field_idx[1:0] == 2'b00) : (field_idx == 3'b000);
    return line_start && (line_num == 10'd1) && fm;
  endfunction

  // reference model: expected outputs after each edge go into the scoreboard
  longint unsigned acc_m = 0;
  bit  synced = 0;
  bit  sw_m   = 0;
  int  st_m   = 0;
  int  dly_m  = 0;
  int  wc_m   = 0;

  always @(posedge clk) begin
    if (rst_n && (synced || is_ref())) begin
      exp_t e;
      bit slp, rf, carry;
      longint unsigned sum;
      int p, ncyc;
      slp = (mode == 2'b11);
      rf  = is_ref();
      p   = int'(acc_m >> 24);
      e.ok  = synced;
      e.slp = slp;
      if (slp) begin
        e.s = 0; e.c = 0; e.v = 0;
      end else begin
        e.s = tab(p);
        e.c = tab(p + 64);
        e.v = sw_m ? -e.c : e.c;
      end
      carry = 1'b0;
      if (slp || rf) acc_m = 0;
      else begin
        sum   = acc_m + step_of(mode);
        carry = sum[32];
        acc_m = sum & 64'hFFFF_FFFF;
      end
      ncyc = (mode == 2'b01) ? 10 : 9;
      if (slp) st_m = 0;
      else if (line_start) begin
        st_m = 1; dly_m = 75; wc_m = 0;
      end else if (st_m == 1) begin
        if (dly_m == 0) begin st_m = 2; wc_m = 0; end
        else dly_m--;
      end else if (st_m == 2 && carry) begin
        if (wc_m == ncyc - 1) st_m = 0;
        else wc_m++;
      end
      if (mode != 2'b01) sw_m = 0;
      else if (line_start) sw_m = ~sw_m;
      e.g  = (st_m == 2) ? 1 : 0;
      e.sw = sw_m ? 1 : 0;
      q.push_back(e);
      synced = 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.ok) begin
        if (e.slp) begin
          chk("R10 sin_o in sleep", int'(sin_o), e.s);
          chk("R10 gate in sleep", int'(burst_gate), e.g);
        end else begin
          chk("R3 sin_o (phase from R2 R4)", int'(sin_o), e.s);
          chk("R3 cos_o (phase from R2 R4)", int'(cos_o), e.c);
          chk("R5 R6 R7 burst_gate", int'(burst_gate), e.g);
        end
        chk("R9 v_o", int'(v_o), e.v);
        chk("R8 pal_sw", int'(pal_sw), e.sw);
      end
    end
  end

  task automatic send_line(input int ln, input int fld, input int len);
    @(negedge clk);
    line_start = 1'b1;
    line_num   = 10'(ln);
    field_idx  = 3'(fld);
    @(negedge clk);
    line_start = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    mode       = 2'b00;
    line_start = 1'b0;
    line_num   = '0;
    field_idx  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sin_o", int'(sin_o), 0);
    chk("R1 cos_o", int'(cos_o), 0);
    chk("R1 v_o", int'(v_o), 0);
    chk("R1 burst_gate", int'(burst_gate), 0);
    chk("R1 pal_sw", int'(pal_sw), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // NTSC: reference, running lines, non-reference field, masked field
    send_line(1, 0, 200);
    send_line(2, 0, 200);
    send_line(3, 0, 200);
    send_line(1, 1, 200);
    send_line(1, 4, 200);
    // R7 restart during open window and during delay
    send_line(5, 0, 120);
    send_line(6, 0, 30);
    send_line(7, 0, 200);

    // PAL
    mode = 2'b01;
    send_line(1, 0, 200);
    send_line(2, 0, 200);
    send_line(3, 0, 200);
    send_line(1, 4, 200);
    send_line(4, 0, 200);
    send_line(1, 0, 200);

    // PAL-M
    mode = 2'b10;
    send_line(1, 0, 200);
    send_line(2, 1, 200);
    send_line(1, 4, 200);

    // sleep with a line start, then wake in PAL
    mode = 2'b11;
    send_line(9, 0, 60);
    mode = 2'b01;
    send_line(2, 0, 200);
    send_line(1, 0, 200);
    mode = 2'b00;
    send_line(1, 0, 200);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule